// File: doc/BRIEF.md
# Four-Way Set-Associative Instruction Cache Controller

This block serves instruction fetches from an 8 KiB cache. The cache has 64 sets of 4 ways, and each line holds 32 bytes. The requester presents a fetch address and holds it until a response appears.

- **Hit:** the stored word comes back in the same cycle, flagged as a hit.
- **Miss:** the controller picks a victim way and reads the whole aligned line from a word-wide memory port, one word at a time, in eight reads. It then returns the requested word flagged as a miss.

Two replacement policies are available, selected by an input pin:

- a per-set round-robin counter;
- a 32-bit multiply-xor pseudo-random generator.

Ways are never marked invalid through a valid bit. Instead they are loaded with a reserved tag value that no real address can produce. Two invalidation commands exist: one that clears the whole cache, and one that clears only the way holding a given address. Both are acted on only while the controller is idle.

Top module: `icache_ctrl`

## Requirements
- R1: A fetch address decodes as follows: tag = bits [31:11], set = bits [10:5], word within the line = bits [4:2]. Bits [1:0] are ignored, so `respData` is always the word at the address with its two low bits cleared.
- R2: A fetch that hits while the controller is idle is answered in the cycle it is presented. In that cycle `respValid`=1 and `respHit`=1, the stored word is returned, and no memory read is made.
- R3: A miss makes exactly eight memory reads. They go to line base + 4·k for k = 0..7, in ascending order, and each address is held on `memAddr` until `memAck`. The cycle after the eighth acknowledge, `respValid`=1 and `respHit`=0, with the requested word from the line just filled.
- R4: While a fill is in progress, `busy` is 1 and `respValid` stays 0. A fetch held during that time is answered only once the fill ends.
- R5: When `rrMode`=1 at a miss, the victim is that set's 2-bit counter, and the counter then increments modulo 4. All counters are 0 after reset.
- R6: When `rrMode`=0 at a miss, a 32-bit state s steps to s ^ (17·s) ^ (7·s), taken modulo 2^32, and the victim is bits [18:17] of the new state. The state is 44203 after reset. Round-robin misses leave the state untouched, and random misses leave the counters untouched.
- R7: An invalid way holds the tag value 1, which never matches. Reset makes all 256 ways invalid, so the first fetch to any line misses.
- R8: Asserting `invAllReq` while idle makes all 256 ways invalid.
- R9: Asserting `invValid` while idle invalidates only the way whose tag matches `invAddr`. The other ways keep their lines, and an address that is not cached has no effect.
- R10: Invalidation inputs asserted while `busy`=1 have no effect.
- R11: In an idle cycle, invalidation takes precedence over a fetch, and `invAllReq` takes precedence over `invValid`. The fetch is not answered in that cycle and is looked up afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rrMode | input | 1 | 1 selects round-robin replacement, 0 selects pseudo-random |
| fetchValid | input | 1 | Fetch request, held until answered |
| fetchAddr | input | 32 | Fetch byte address, held with fetchValid |
| respValid | output | 1 | Fetch answered this cycle |
| respHit | output | 1 | 1 for a hit answer, 0 for an answer after a fill |
| respData | output | 32 | Requested instruction word |
| busy | output | 1 | Fill or post-fill answer in progress |
| invAllReq | input | 1 | Invalidate every way |
| invValid | input | 1 | Invalidate the way matching invAddr |
| invAddr | input | 32 | Address for single-line invalidation |
| memReq | output | 1 | Memory word read request |
| memAddr | output | 32 | Memory word address |
| memAck | input | 1 | Read data valid, one pulse per word |
| memData | input | 32 | Read data |

## Verification
The bench sweeps every set with more tags than there are ways, so evictions keep happening. It predicts each victim from its own copies of the counters and the random state, and a wrong step or a wrong bit slice in either policy shows up as a hit where a miss was expected, or the reverse.

It varies memory latency, checks every fill address, and checks the data word. A fill that skipped, reordered or misaligned a word would return the wrong instruction.

Invalidation is exercised three ways:
- pulsed in the middle of a fill, where a design that obeyed it would lose lines the model still holds;
- presented together with a fetch, where a design that answered first would return stale data;
- aimed at a single address, where a design that cleared the wrong way would miss on lines that should still hit.

// File: rtl/icache_pkg.sv
package icache_pkg;

  localparam logic [31:0] RNG_SEED = 32'd44203;
  localparam int          RNG_TAP  = 17;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_RESP
  } ctlState_t;

  typedef struct packed {
    logic invAll;
    logic invOne;
    logic pickVictim;
    logic wordWr;
    logic tagWr;
  } dpStrobe_t;

endpackage

// File: rtl/icache_datapath.sv
module icache_datapath
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              rrMode,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] invAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              hit,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              lastWord
);

  localparam int WAY_W   = $clog2(WAYS);
  localparam int IDX_W   = $clog2(SETS);
  localparam int WRD_W   = $clog2(WORDS);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int OFF_W   = WRD_W + BYTE_W;
  localparam int TAG_LSB = OFF_W + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int ENTRIES = WAYS * SETS;
  localparam int LINES_W = WAY_W + IDX_W + WRD_W;
  localparam logic [ADDR_W-1:0] INVALID_TAG = ADDR_W'(1);

  logic [ADDR_W-1:0] tagMem  [ENTRIES];
  logic [DATA_W-1:0] dataMem [ENTRIES * WORDS];
  logic [WAY_W-1:0]  rrCnt   [SETS];
  logic [31:0]       rngState;
  logic [31:0]       rngNext;

  logic [WAY_W-1:0]  fillWay;
  logic [IDX_W-1:0]  fillSet;
  logic [TAG_W-1:0]  fillTag;
  logic [WRD_W-1:0]  wordCnt;

  logic [ADDR_W-1:0] lookAddr;
  logic [IDX_W-1:0]  lookSet;
  logic [ADDR_W-1:0] lookTagWord;
  logic [WRD_W-1:0]  rdWord;
  logic [WAY_W-1:0]  hitWay;
  logic [WAY_W-1:0]  victim;

  assign lookAddr    = strobe.invOne ? invAddr : fetchAddr;
  assign lookSet     = lookAddr[TAG_LSB-1:OFF_W];
  assign lookTagWord = {lookAddr[ADDR_W-1:TAG_LSB], {TAG_LSB{1'b0}}};
  assign rdWord      = fetchAddr[OFF_W-1:BYTE_W];

  // Way 0 has priority; only one way can hold a given tag.
  always_comb begin
    hit    = 1'b0;
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (tagMem[{lookSet, WAY_W'(w)}] == lookTagWord) begin
        hit    = 1'b1;
        hitWay = WAY_W'(w);
      end
    end
  end

  assign rdData = dataMem[LINES_W'({hitWay, lookSet, rdWord})];

  assign rngNext = rngState ^ (rngState * 32'd17) ^ (rngState * 32'd7);
  assign victim  = rrMode ? rrCnt[lookSet] : rngNext[RNG_TAP +: WAY_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) tagMem[i] <= INVALID_TAG;
      for (int s = 0; s < SETS; s++) rrCnt[s] <= '0;
      rngState <= RNG_SEED;
      fillWay  <= '0;
      fillSet  <= '0;
      fillTag  <= '0;
      wordCnt  <= '0;
    end else begin
      if (strobe.invAll) begin
        for (int i = 0; i < ENTRIES; i++) tagMem[i] <= INVALID_TAG;
      end else if (strobe.invOne && hit) begin
        tagMem[{lookSet, hitWay}] <= INVALID_TAG;
      end
      if (strobe.pickVictim) begin
        fillWay <= victim;
        fillSet <= lookSet;
        fillTag <= lookAddr[ADDR_W-1:TAG_LSB];
        wordCnt <= '0;
        if (rrMode) rrCnt[lookSet] <= rrCnt[lookSet] + 1'b1;
        else        rngState       <= rngNext;
      end
      if (strobe.wordWr) wordCnt <= wordCnt + 1'b1;
      if (strobe.tagWr) tagMem[{fillSet, fillWay}] <= {fillTag, {TAG_LSB{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wordWr) dataMem[LINES_W'({fillWay, fillSet, wordCnt})] <= memData;
  end

  assign memAddr  = {fillTag, fillSet, wordCnt, {BYTE_W{1'b0}}};
  assign lastWord = (wordCnt == WRD_W'(WORDS - 1));

endmodule

// File: rtl/icache_control.sv
module icache_control
  import icache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fetchValid,
  input  logic      invAllReq,
  input  logic      invValid,
  input  logic      hit,
  input  logic      memAck,
  input  logic      lastWord,
  output dpStrobe_t strobe,
  output logic      respValid,
  output logic      respHit,
  output logic      memReq,
  output logic      busy
);

  ctlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    respValid = 1'b0;
    respHit   = 1'b0;
    memReq    = 1'b0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (invAllReq) begin
          strobe.invAll = 1'b1;
        end else if (invValid) begin
          strobe.invOne = 1'b1;
        end else if (fetchValid) begin
          if (hit) begin
            respValid = 1'b1;
            respHit   = 1'b1;
          end else begin
            strobe.pickVictim = 1'b1;
            stateNext         = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.wordWr = 1'b1;
          if (lastWord) begin
            strobe.tagWr = 1'b1;
            stateNext    = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        respValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rrMode,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              respValid,
  output logic              respHit,
  output logic [DATA_W-1:0] respData,
  output logic              busy,
  input  logic              invAllReq,
  input  logic              invValid,
  input  logic [ADDR_W-1:0] invAddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData
);

  dpStrobe_t strobe;
  logic      hit;
  logic      lastWord;

  icache_control ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .fetchValid(fetchValid),
    .invAllReq (invAllReq),
    .invValid  (invValid),
    .hit       (hit),
    .memAck    (memAck),
    .lastWord  (lastWord),
    .strobe    (strobe),
    .respValid (respValid),
    .respHit   (respHit),
    .memReq    (memReq),
    .busy      (busy)
  );

  icache_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WAYS  (WAYS),
    .SETS  (SETS),
    .WORDS (WORDS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rrMode   (rrMode),
    .fetchAddr(fetchAddr),
    .invAddr  (invAddr),
    .memData  (memData),
    .hit      (hit),
    .rdData   (respData),
    .memAddr  (memAddr),
    .lastWord (lastWord)
  );

endmodule

// File: rtl/icache_ctrl_chk.sv
module icache_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchValid,
  input logic              respValid,
  input logic              respHit,
  input logic              busy,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WRD_W  = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + WRD_W;

  // Hit answers never touch memory (R2).
  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respHit |-> !memReq);

  // Answers only go to a request that is still held (R2).
  p_resp_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> fetchValid);

  // A pending read holds its address until acknowledged (R3).
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));

  // Accepted non-final word is followed by the next word address (R3).
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && (memAddr[OFF_W-1:BYTE_W] != {WRD_W{1'b1}})
    |=> memReq && (memAddr == $past(memAddr) + ADDR_W'(DATA_W / 8)));

  // Final word acknowledged: a miss answer follows next cycle (R3).
  p_fill_answer_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && (memAddr[OFF_W-1:BYTE_W] == {WRD_W{1'b1}})
    |=> respValid && !respHit && !memReq);

  // No answer while memory is being read (R4).
  p_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy && !respValid);

  // Reads start at a word boundary (R3).
  p_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[BYTE_W-1:0] == '0));

endmodule

bind icache_ctrl icache_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WORDS (WORDS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .fetchValid(fetchValid),
  .respValid (respValid),
  .respHit   (respHit),
  .busy      (busy),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .memAck    (memAck)
);

// File: tb/icache_ctrl_tb_top.sv
module icache_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rrMode;
  logic        fetchValid;
  logic [31:0] fetchAddr;
  logic        respValid;
  logic        respHit;
  logic [31:0] respData;
  logic        busy;
  logic        invAllReq;
  logic        invValid;
  logic [31:0] invAddr;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck;
  logic [31:0] memData;

  int nChk = 0;
  int nBad = 0;
  int readCnt = 0;
  int memLat = 0;
  int waitCnt = 0;
  logic [31:0] expBase = '0;

  logic [31:0] mTag [256];
  logic [1:0]  mRr  [64];
  logic [31:0] mRng;

  always #(CLK_PERIOD / 2) clk = ~clk;

  icache_ctrl dut_i (
    .clk(clk), .rstN(rstN), .rrMode(rrMode),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .respValid(respValid), .respHit(respHit), .respData(respData), .busy(busy),
    .invAllReq(invAllReq), .invValid(invValid), .invAddr(invAddr),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'h5A5A_5A5A;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  endtask

  // Memory responder: one acknowledge per word, memLat idle cycles first.
  initial begin
    memAck  = 1'b0;
    memData = '0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck  = 1'b0;
        waitCnt = 0;
      end else if (memReq) begin
        if (waitCnt >= memLat) begin
          memAck  = 1'b1;
          memData = memWord(memAddr);
          chk("R3", "fill address", memAddr, expBase + 32'(readCnt * 4));
          readCnt++;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  // Reference model helpers
  task automatic mReset();
    for (int i = 0; i < 256; i++) mTag[i] = 32'd1;
    for (int s = 0; s < 64; s++) mRr[s] = 2'd0;
    mRng = 32'd44203;
  endtask

  task automatic mLook(input logic [31:0] a, output bit h, output int way);
    int s;
    s   = int'(a[10:5]);
    h   = 0;
    way = 0;
    for (int w = 3; w >= 0; w--)
      if (mTag[s * 4 + w] == {a[31:11], 11'b0}) begin h = 1; way = w; end
  endtask

  task automatic mFill(input logic [31:0] a);
    int s;
    logic [1:0] v;
    s = int'(a[10:5]);
    if (rrMode) begin
      v = mRr[s];
      mRr[s] = mRr[s] + 2'd1;
    end else begin
      mRng = mRng ^ (mRng * 32'd17) ^ (mRng * 32'd7);
      v = mRng[18:17];
    end
    mTag[s * 4 + int'(v)] = {a[31:11], 11'b0};
  endtask

  task automatic mInv(input bit all, input logic [31:0] a);
    bit h;
    int w;
    if (all) begin
      for (int i = 0; i < 256; i++) mTag[i] = 32'd1;
    end else begin
      mLook(a, h, w);
      if (h) mTag[int'(a[10:5]) * 4 + w] = 32'd1;
    end
  endtask

  // mode 0 plain, 1 invalidation pulses mid-fill, 2 invalidation with the fetch
  task automatic doFetch(input logic [31:0] a, input int mode, input string req);
    bit expHit;
    int way;
    int cyc;
    string tagReq;
    tagReq = (mode == 1) ? "R10" : (mode == 2) ? "R11" : req;
    readCnt = 0;
    expBase = {a[31:5], 5'b0};
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = a;
    if (mode == 2) begin
      invValid = 1'b1;
      invAddr  = a;
      mInv(0, a);
    end
    #1;
    mLook(a, expHit, way);
    if (mode == 2) chk("R11", "answer during invalidate", {31'b0, respValid}, 32'd0);
    cyc = 0;
    while (!respValid && cyc < 500) begin
      @(negedge clk);
      #1;
      cyc++;
      if (mode == 2 && cyc == 1) begin invValid = 1'b0; #1; end
      if (mode == 1 && cyc == 2) begin
        invAllReq = 1'b1; invValid = 1'b1; invAddr = a; #1;
      end
      if (mode == 1 && cyc == 3) begin invAllReq = 1'b0; invValid = 1'b0; #1; end
      if (!expHit && cyc == ((mode == 2) ? 2 : 1))
        chk("R4", "busy during fill", {31'b0, busy}, 32'd1);
    end
    if (cyc >= 500) begin
      nChk++; nBad++;
      $display("FAIL R4 no answer: actual=timeout expected=answer");
    end
    chk(tagReq, "hit flag", {31'b0, respHit}, {31'b0, expHit});
    chk("R1", "data word", respData, memWord({a[31:2], 2'b00}));
    chk("R3", "read count", 32'(readCnt), expHit ? 32'd0 : 32'd8);
    if (expHit && mode != 2) chk("R2", "hit latency", 32'(cyc), 32'd0);
    if (!expHit) mFill(a);
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  task automatic doInv(input bit all, input logic [31:0] a);
    @(negedge clk);
    invAllReq = all;
    invValid  = !all;
    invAddr   = a;
    @(negedge clk);
    invAllReq = 1'b0;
    invValid  = 1'b0;
    mInv(all, a);
  endtask

  function automatic logic [31:0] mkAddr(input int tg, input int st, input int wd, input int lo);
    return {21'(tg), 6'(st), 3'(wd), 2'(lo)};
  endfunction

  // Watchdog
  initial begin
    #(CLK_PERIOD * 190000);
    nChk++; nBad++;
    $display("FAIL R4 watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    logic [31:0] lcg;
    rstN = 1'b0; rrMode = 1'b1; fetchValid = 1'b0; fetchAddr = '0;
    invAllReq = 1'b0; invValid = 1'b0; invAddr = '0;
    mReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R7", "reset respValid", {31'b0, respValid}, 32'd0);
    chk("R7", "reset busy", {31'b0, busy}, 32'd0);
    chk("R7", "reset memReq", {31'b0, memReq}, 32'd0);

    // Round-robin sweep over every set, five tags per set (R5, R7)
    rrMode = 1'b1;
    memLat = 0;
    for (int st = 0; st < 64; st++) begin
      for (int t = 0; t < 5; t++) doFetch(mkAddr(t + 1, st, t + st, t), 0, "R7");
      for (int t = 0; t < 5; t++) doFetch(mkAddr(t + 1, st, 7 - t, 3 - t % 4), 0, "R5");
      doFetch(mkAddr(5, st, 2, 0), 0, "R5");
    end

    // Full invalidation then random replacement (R8, R6)
    doInv(1, '0);
    doFetch(mkAddr(1, 0, 0, 0), 0, "R8");
    rrMode = 1'b0;
    memLat = 1;
    for (int st = 0; st < 16; st++)
      for (int pass = 0; pass < 2; pass++)
        for (int t = 0; t < 6; t++) doFetch(mkAddr(t + 9, st, t + pass, pass), 0, "R6");

    // Mixed traffic with invalidations (R9, R10, R11)
    lcg = 32'd12345;
    for (int k = 0; k < 600; k++) begin
      logic [31:0] a;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      a = mkAddr(int'(lcg[20:18]) + 1, int'(lcg[17:16]), int'(lcg[15:13]), int'(lcg[12:11]));
      rrMode = ((k / 8) % 2) == 1;
      memLat = k % 3;
      if (k % 41 == 0)      doInv(1, a);
      else if (k % 13 == 0) doInv(0, a);
      else if (k % 17 == 0) doFetch(a, 1, "R10");
      else if (k % 19 == 0) doFetch(a, 2, "R11");
      else                  doFetch(a, 0, "R9");
    end

    summary();
  end

endmodule